// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Access

This block is a general-purpose I/O port of up to 32 pins (16 by default), controlled over a simple register bus. Each pin has its own direction bit and input-buffer enable. The output value can be changed in four ways. Three write-one registers set, clear or invert only the bits written as 1. A fourth register loads the whole value. Because of this, software can change a few pins with a single write and never needs a read-modify-write sequence.

Each pin can raise an interrupt. Pin inputs pass through a two-stage synchroniser before they are used. Interrupt enables are changed through their own set and clear registers. Each pin is either level-sensitive or edge-sensitive. An edge-sensitive pin reacts to the rising edge only, or to both edges. Edge events are held in a pending register until software clears them. A pin driven as an output is also a source for its own interrupt, so software can trigger an interrupt by writing that pin's data bit.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset every pin has its output driver off (`pin_oe` = 0) and its input buffer off (`pin_ie` = 0). The output value is 0, all interrupt enables are 0 and `irq` is low.
- R2: The direction register (address 4, 1 = output) drives `pin_oe` one cycle after it is written. `pin_out` always carries the output value register.
- R3: Writing to address 1 sets, address 2 clears and address 3 inverts only those output bits whose write-data bit is 1. All other bits keep their value.
- R4: Writing to address 0 replaces the whole output value with the write data.
- R5: Reading address 0 returns the pin state. For an output pin this is the driven value. For an input pin it is the input value after the two-stage synchroniser, seen two clock edges after it changes at `pin_in`.
- R6: Writing to address 6 enables, and writing to address 7 disables, the interrupt of only those pins whose write-data bit is 1. Reading address 6 or 7 returns the enable register.
- R7: A pin whose bit at address 8 is 0 is level-sensitive. While its state is high and it is enabled, `irq` is high. When the state falls, `irq` drops and nothing is held.
- R8: A pin whose bit at address 8 is 1 is edge-sensitive. If its bit at address 9 is 0, a rising edge of its state sets a pending bit and a falling edge is ignored. The pending bit stays set until software writes 1 to that bit at address 10. Reading address 10 returns the pending bits for edge pins and the pin state for level pins.
- R9: An edge-sensitive pin whose bit at address 9 is 1 sets its pending bit on both rising and falling edges.
- R10: If an edge is detected in the same cycle that software writes 1 to that pin's bit at address 10, the clear wins. The pending bit ends up 0.
- R11: A pin configured as an output feeds its driven value into the interrupt logic. Setting its data bit therefore raises an edge interrupt one cycle after the write.
- R12: An input pin whose buffer-enable bit (address 5) is 0 reads as 0 and cannot raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for write and read |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for `bus_addr`, combinational |
| pin_in | input | NPIN | Pin input levels, asynchronous |
| pin_out | output | NPIN | Output value register |
| pin_oe | output | NPIN | Output driver enable per pin |
| pin_ie | output | NPIN | Input buffer enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle:
- that the set, clear, invert and load writes change exactly the bits they should;
- that enables change only on their own writes;
- that a level source that is both enabled and high keeps `irq` high;
- that a rising edge latches a pending bit;
- that a pending bit falls only when it is cleared;
- that a clear always wins over a new edge.

Only the bench scenarios can show the other behaviours:
- the two-edge input latency;
- that a falling edge is ignored in rising-only mode and latched in both-edge mode;
- the software-triggered interrupt from an output pin;
- that a disabled input buffer hides the pin from both the data read and the interrupt.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

   localparam int REG_ADDR_W = 4;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_DATA = 4'd0,
      RA_SET  = 4'd1,
      RA_CLR  = 4'd2,
      RA_TGL  = 4'd3,
      RA_DIR  = 4'd4,
      RA_INEN = 4'd5,
      RA_MSET = 4'd6,
      RA_MCLR = 4'd7,
      RA_EDGE = 4'd8,
      RA_BOTH = 4'd9,
      RA_STAT = 4'd10
   } reg_addr_e;

endpackage

// File: rtl/gpio_atomic_sync.sv
module gpio_atomic_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_atomic_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_atomic_regs.sv
module gpio_atomic_regs
   import gpio_atomic_pkg::*;
#(
   parameter int W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]          bus_wdata,
   input  logic [W-1:0]          pin_state,
   input  logic [W-1:0]          status,
   output logic [W-1:0]          bus_rdata,
   output logic [W-1:0]          dout_q,
   output logic [W-1:0]          dir_q,
   output logic [W-1:0]          inen_q,
   output logic [W-1:0]          mask_q,
   output logic [W-1:0]          edge_q,
   output logic [W-1:0]          both_q,
   output logic [W-1:0]          stat_clr
);

   reg_addr_e sel;
   assign sel = reg_addr_e'(bus_addr);

   // write-one vectors: zero unless the matching register is written
   logic [W-1:0] d_set, d_clr, d_tgl, m_set, m_clr;
   logic         d_load;

   assign d_load   = bus_we && (sel == RA_DATA);
   assign d_set    = (bus_we && sel == RA_SET)  ? bus_wdata : '0;
   assign d_clr    = (bus_we && sel == RA_CLR)  ? bus_wdata : '0;
   assign d_tgl    = (bus_we && sel == RA_TGL)  ? bus_wdata : '0;
   assign m_set    = (bus_we && sel == RA_MSET) ? bus_wdata : '0;
   assign m_clr    = (bus_we && sel == RA_MCLR) ? bus_wdata : '0;
   assign stat_clr = (bus_we && sel == RA_STAT) ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
         inen_q <= '0;
         mask_q <= '0;
         edge_q <= '0;
         both_q <= '0;
      end else begin
         if (d_load) dout_q <= bus_wdata;
         else        dout_q <= ((dout_q | d_set) & ~d_clr) ^ d_tgl;
         mask_q <= (mask_q | m_set) & ~m_clr;
         if (bus_we && sel == RA_DIR)  dir_q  <= bus_wdata;
         if (bus_we && sel == RA_INEN) inen_q <= bus_wdata;
         if (bus_we && sel == RA_EDGE) edge_q <= bus_wdata;
         if (bus_we && sel == RA_BOTH) both_q <= bus_wdata;
      end
   end

   always_comb begin
      case (sel)
         RA_DATA:                 bus_rdata = pin_state;
         RA_SET, RA_CLR, RA_TGL:  bus_rdata = dout_q;
         RA_DIR:                  bus_rdata = dir_q;
         RA_INEN:                 bus_rdata = inen_q;
         RA_MSET, RA_MCLR:        bus_rdata = mask_q;
         RA_EDGE:                 bus_rdata = edge_q;
         RA_BOTH:                 bus_rdata = both_q;
         RA_STAT:                 bus_rdata = status;
         default:                 bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_atomic_irq.sv
module gpio_atomic_irq #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic [W-1:0] edge_sel,
   input  logic [W-1:0] both_sel,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] clr,
   output logic [W-1:0] prev_q,
   output logic [W-1:0] pend_q,
   output logic [W-1:0] status,
   output logic         irq
);

   logic [W-1:0] hit;

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      assign rise   = src[i] & ~prev_q[i];
      assign fall   = ~src[i] & prev_q[i];
      assign hit[i] = edge_sel[i] & (rise | (both_sel[i] & fall));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= src;
         pend_q <= (pend_q | hit) & ~clr;   // clear has priority
      end
   end

   assign status = (pend_q & edge_sel) | (src & ~edge_sel);
   assign irq    = |(status & mask);

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port #(
   parameter int NPIN        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   bus_we,
   input  logic [gpio_atomic_pkg::REG_ADDR_W-1:0] bus_addr,
   input  logic [NPIN-1:0]                        bus_wdata,
   output logic [NPIN-1:0]                        bus_rdata,
   input  logic [NPIN-1:0]                        pin_in,
   output logic [NPIN-1:0]                        pin_out,
   output logic [NPIN-1:0]                        pin_oe,
   output logic [NPIN-1:0]                        pin_ie,
   output logic                                   irq
);

   if (NPIN < 1 || NPIN > 32) begin : g_bad_npin
      $error("gpio_atomic_port: NPIN must lie in 1..32");
   end

   logic [NPIN-1:0] sync_w, src_w, status_w, prev_w, pend_w, stat_clr_w;
   logic [NPIN-1:0] dout_w, dir_w, inen_w, mask_w, edge_w, both_w;

   gpio_atomic_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_w)
   );

   gpio_atomic_regs #(.W(NPIN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pin_state (src_w),
      .status    (status_w),
      .bus_rdata (bus_rdata),
      .dout_q    (dout_w),
      .dir_q     (dir_w),
      .inen_q    (inen_w),
      .mask_q    (mask_w),
      .edge_q    (edge_w),
      .both_q    (both_w),
      .stat_clr  (stat_clr_w)
   );

   // pin state: driven value on outputs, gated synchronised input otherwise
   assign src_w = (dir_w & dout_w) | (~dir_w & inen_w & sync_w);

   gpio_atomic_irq #(.W(NPIN)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_w),
      .edge_sel (edge_w),
      .both_sel (both_w),
      .mask     (mask_w),
      .clr      (stat_clr_w),
      .prev_q   (prev_w),
      .pend_q   (pend_w),
      .status   (status_w),
      .irq      (irq)
   );

   assign pin_out = dout_w;
   assign pin_oe  = dir_w;
   assign pin_ie  = inen_w;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk
   import gpio_atomic_pkg::*;
#(
   parameter int NPIN = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_we,
   input logic [REG_ADDR_W-1:0] bus_addr,
   input logic [NPIN-1:0]       bus_wdata,
   input logic [NPIN-1:0]       pin_out,
   input logic [NPIN-1:0]       pin_oe,
   input logic                  irq,
   input logic [NPIN-1:0]       src,
   input logic [NPIN-1:0]       src_prev,
   input logic [NPIN-1:0]       pend,
   input logic [NPIN-1:0]       stat_clr,
   input logic [NPIN-1:0]       mask,
   input logic [NPIN-1:0]       edge_sel
);

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R1

   AST_SET_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R3

   AST_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_CLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R3

   AST_TGL_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_TGL) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata))); // R3

   AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_DATA) |=> pin_out == $past(bus_wdata)); // R4

   AST_MASK_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_MSET) |=> mask == ($past(mask) | $past(bus_wdata))); // R6

   AST_MASK_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_MCLR) |=> mask == ($past(mask) & ~$past(bus_wdata))); // R6

   AST_LEVEL_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mask & ~edge_sel & src)) |-> irq); // R7

   AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(edge_sel & src & ~src_prev & ~stat_clr)) |=> (|pend)); // R8

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend) & ~pend & ~$past(stat_clr)) == '0)); // R8

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_clr) |=> ((pend & $past(stat_clr)) == '0)); // R10

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.NPIN(NPIN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .src       (src_w),
   .src_prev  (prev_w),
   .pend      (pend_w),
   .stat_clr  (stat_clr_w),
   .mask      (mask_w),
   .edge_sel  (edge_w)
);

// File: tb/tb_gpio_atomic_port.sv
`timescale 1ns/100ps
module tb_gpio_atomic_port;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_we;
   logic [3:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in;
   logic [15:0] pin_out, pin_oe, pin_ie;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   gpio_atomic_port dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_dout = '0, m_dir = '0, m_inen = '0, m_mask = '0;
   logic [15:0] m_edge = '0, m_both = '0, m_pend = '0, m_prev = '0;
   logic [15:0] m_syncq [$] = '{16'h0, 16'h0};   // [0] = second stage
   logic [15:0] t_src, t_hit, t_clr;

   function automatic logic [15:0] m_src();
      return (m_dir & m_dout) | (~m_dir & m_inen & m_syncq[0]);
   endfunction

   function automatic logic [15:0] m_stat();
      return (m_pend & m_edge) | (m_src() & ~m_edge);
   endfunction

   function automatic logic m_irq();
      return |(m_stat() & m_mask);
   endfunction

   function automatic logic [15:0] m_read(input logic [3:0] a);
      case (a)
         4'd0:             return m_src();
         4'd1, 4'd2, 4'd3: return m_dout;
         4'd4:             return m_dir;
         4'd5:             return m_inen;
         4'd6, 4'd7:       return m_mask;
         4'd8:             return m_edge;
         4'd9:             return m_both;
         4'd10:            return m_stat();
         default:          return 16'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dout = '0; m_dir = '0; m_inen = '0; m_mask = '0;
         m_edge = '0; m_both = '0; m_pend = '0; m_prev = '0;
         m_syncq = '{16'h0, 16'h0};
      end else begin
         t_src  = m_src();
         t_hit  = m_edge & ((t_src & ~m_prev) | (m_both & ~t_src & m_prev));
         t_clr  = (bus_we && bus_addr == 4'd10) ? bus_wdata : 16'h0;
         m_pend = (m_pend | t_hit) & ~t_clr;
         m_prev = t_src;
         m_syncq.push_back(pin_in);
         void'(m_syncq.pop_front());
         if (bus_we) begin
            case (bus_addr)
               4'd0: m_dout = bus_wdata;
               4'd1: m_dout = m_dout | bus_wdata;
               4'd2: m_dout = m_dout & ~bus_wdata;
               4'd3: m_dout = m_dout ^ bus_wdata;
               4'd4: m_dir  = bus_wdata;
               4'd5: m_inen = bus_wdata;
               4'd6: m_mask = m_mask | bus_wdata;
               4'd7: m_mask = m_mask & ~bus_wdata;
               4'd8: m_edge = bus_wdata;
               4'd9: m_both = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n === 1'b1 && !done) begin
         chk("R2 model pin_oe", {16'h0, pin_oe}, {16'h0, m_dir});
         chk("R3 model pin_out", {16'h0, pin_out}, {16'h0, m_dout});
         chk("R7 model irq", {31'h0, irq}, {31'h0, m_irq()});
         chk("R5 model bus_rdata", {16'h0, bus_rdata}, {16'h0, m_read(bus_addr)});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
      #0.5;
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); @(negedge clk); #0.5;
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #0.3;
      d = bus_rdata;
   endtask

   logic [15:0] rv;

   initial begin
      #20000;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = 4'd0; bus_wdata = '0; pin_in = '0;
      repeat (4) @(posedge clk);
      #1;
      chk("R1 reset pin_oe", {16'h0, pin_oe}, 32'h0);
      chk("R1 reset pin_ie", {16'h0, pin_ie}, 32'h0);
      chk("R1 reset irq", {31'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1; #0.5;
      rd(4'd6, rv); chk("R1 reset mask", {16'h0, rv}, 32'h0);

      wr(4'd4, 16'h00FF); chk("R2 direction", {16'h0, pin_oe}, 32'h00FF);
      wr(4'd0, 16'hA5A5); chk("R4 direct load", {16'h0, pin_out}, 32'hA5A5);
      wr(4'd1, 16'h000F); chk("R3 set", {16'h0, pin_out}, 32'hA5AF);
      wr(4'd2, 16'h0101); chk("R3 clear", {16'h0, pin_out}, 32'hA4AE);
      wr(4'd3, 16'hFF00); chk("R3 toggle", {16'h0, pin_out}, 32'h5BAE);

      pin_in = 16'h3C00; cyc(3);
      rd(4'd0, rv); chk("R12 disabled input reads 0", {16'h0, rv}, 32'h00AE);
      wr(4'd6, 16'h0400); cyc(1);
      chk("R12 disabled input no irq", {31'h0, irq}, 32'h0);
      wr(4'd5, 16'hFF00);
      rd(4'd0, rv); chk("R5 pin state read", {16'h0, rv}, 32'h3CAE);
      chk("R7 level irq after enable", {31'h0, irq}, 32'h1);
      wr(4'd7, 16'h0400); chk("R6 clear enable drops irq", {31'h0, irq}, 32'h0);

      wr(4'd6, 16'h0300); wr(4'd6, 16'h0001);
      rd(4'd6, rv); chk("R6 set only ones", {16'h0, rv}, 32'h0301);
      wr(4'd7, 16'h0100);
      rd(4'd7, rv); chk("R6 clear only ones", {16'h0, rv}, 32'h0201);

      pin_in = 16'h3E00; cyc(1);
      rd(4'd0, rv); chk("R5 one edge: still old", {16'h0, rv}, 32'h3CAE);
      cyc(1);
      rd(4'd0, rv); chk("R5 two edges: new", {16'h0, rv}, 32'h3EAE);
      chk("R7 level high irq", {31'h0, irq}, 32'h1);
      pin_in = 16'h3C00; cyc(2);
      chk("R7 level not held", {31'h0, irq}, 32'h0);

      wr(4'd8, 16'h0201);
      pin_in = 16'h3E00; cyc(2);
      chk("R8 no pend before third edge", {31'h0, irq}, 32'h0);
      cyc(1);
      chk("R8 rising latched", {31'h0, irq}, 32'h1);
      rd(4'd10, rv); chk("R8 status bit", {31'h0, rv[9]}, 32'h1);
      pin_in = 16'h3C00; cyc(3);
      chk("R8 held after fall", {31'h0, irq}, 32'h1);
      wr(4'd10, 16'h0200); chk("R8 cleared", {31'h0, irq}, 32'h0);
      pin_in = 16'h3E00; cyc(3); wr(4'd10, 16'h0200);
      pin_in = 16'h3C00; cyc(3);
      chk("R8 falling ignored", {31'h0, irq}, 32'h0);

      wr(4'd9, 16'h0200);
      pin_in = 16'h3E00; cyc(3);
      chk("R9 rising latched", {31'h0, irq}, 32'h1);
      wr(4'd10, 16'h0200);
      pin_in = 16'h3C00; cyc(3);
      chk("R9 falling latched", {31'h0, irq}, 32'h1);
      wr(4'd10, 16'h0200);

      pin_in = 16'h3E00;
      @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk); #0.5;
      wr(4'd10, 16'h0200);
      chk("R10 clear wins", {31'h0, irq}, 32'h0);
      cyc(2);
      chk("R10 edge stays lost", {31'h0, irq}, 32'h0);

      wr(4'd1, 16'h0001);
      chk("R11 no pend yet", {31'h0, irq}, 32'h0);
      cyc(1);
      chk("R11 software interrupt", {31'h0, irq}, 32'h1);
      wr(4'd10, 16'h0001);
      chk("R11 cleared", {31'h0, irq}, 32'h0);

      cyc(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule